// File: doc/BRIEF.md
# Bicolour Status LED Pattern Generator

This block turns a set of supply condition flags into the drive for a two-colour (green and amber) status lamp. A fixed priority picks one of six display patterns: dark, solid green, slow green blink, slow amber blink, solid amber and fast green blink. The slow rate is 1 Hz and the fast rate is 2 Hz, both derived from a clock-frequency parameter by a counter on the system clock.

The condition flags come from supply monitoring logic elsewhere. The block only ranks those flags and times the blinking. Whenever the selected pattern changes, the blink phase restarts at the start of its lit half. The new pattern then shows with a fixed latency of one clock.

Top module: `status_led_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with all flags low, `led_green` and `led_amber` are both 0.
- R2: With `main_good` high and no higher-ranked flag, `led_green` is steadily 1 and `led_amber` 0.
- R3: With no flag high, or with `standby_only` high but `ac_good` low and no other flag, both outputs are 0.
- R4: With `ac_good` and `standby_only` high and no higher-ranked flag, green blinks at 1 Hz: CLK_HZ/2 cycles lit, CLK_HZ/2 cycles dark, and amber stays 0.
- R5: With `warn_run` high and neither `crit_stop` nor `fw_update` high, amber blinks at 1 Hz with CLK_HZ/2-cycle halves, and green stays 0.
- R6: With `crit_stop` high and `fw_update` low, `led_amber` is steadily 1 and `led_green` 0.
- R7: With `fw_update` high, green blinks at 2 Hz: CLK_HZ/4 cycles lit, CLK_HZ/4 cycles dark, and amber stays 0.
- R8: Ranking from highest to lowest is `fw_update`, `crit_stop`, `warn_run`, `main_good`, standby (`ac_good` and `standby_only`), then dark.
- R9: `led_green` and `led_amber` are never 1 in the same cycle.
- R10: When the selected pattern changes, the blink starts over with a full lit half, whatever point the previous blink had reached.
- R11: A flag change sampled at a rising clock edge shows on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst | input | 1 | Synchronous active-high reset |
| ac_good | input | 1 | Input power present |
| main_good | input | 1 | Main output on and in regulation |
| standby_only | input | 1 | Only the standby rail is running |
| warn_run | input | 1 | Warning active, supply still running |
| crit_stop | input | 1 | Critical event has shut the supply down |
| fw_update | input | 1 | Firmware-update mode |
| led_green | output | 1 | Green lamp drive, active high |
| led_amber | output | 1 | Amber lamp drive, active high |

## Verification
The bench builds the block with CLK_HZ set to 16, which gives an 8-cycle half period for the slow blink and a 4-cycle half period for the fast blink. Several complete blink periods of each rate then fit in a few dozen cycles, so every half-period boundary can be compared cycle by cycle. A pattern switch made in the dark half of a slow blink is also cheap to set up, and it shows whether the phase restarts.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    // Display patterns, one per ranked supply state
    typedef enum logic [2:0] {
        PAT_DARK        = 3'd0,
        PAT_GREEN_ON    = 3'd1,
        PAT_GREEN_SLOW  = 3'd2,
        PAT_AMBER_SLOW  = 3'd3,
        PAT_AMBER_ON    = 3'd4,
        PAT_GREEN_FAST  = 3'd5
    } led_pat_e;

    typedef enum logic [1:0] {
        RATE_SOLID = 2'd0,
        RATE_SLOW  = 2'd1,
        RATE_FAST  = 2'd2
    } blink_rate_e;

    typedef struct packed {
        logic fw_update;
        logic crit_stop;
        logic warn_run;
        logic main_good;
        logic standby_only;
        logic ac_good;
    } supply_cond_t;

    typedef struct packed {
        logic green;
        logic amber;
    } led_drive_t;

    function automatic blink_rate_e pat_rate(input led_pat_e p);
        case (p)
            PAT_GREEN_SLOW, PAT_AMBER_SLOW: return RATE_SLOW;
            PAT_GREEN_FAST:                 return RATE_FAST;
            default:                        return RATE_SOLID;
        endcase
    endfunction

    // Colour shown during the lit half of a pattern
    function automatic led_drive_t pat_colour(input led_pat_e p);
        led_drive_t d;
        d = '0;
        case (p)
            PAT_GREEN_ON, PAT_GREEN_SLOW, PAT_GREEN_FAST: d.green = 1'b1;
            PAT_AMBER_ON, PAT_AMBER_SLOW:                 d.amber = 1'b1;
            default:                                      d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/led_prio_sel.sv
module led_prio_sel
    import led_status_pkg::*;
(
    input  supply_cond_t cond,
    output led_pat_e     pat_sel
);
    // Fixed ranking: update mode, critical, warning, output good, standby
    always_comb begin
        if (cond.fw_update)
            pat_sel = PAT_GREEN_FAST;
        else if (cond.crit_stop)
            pat_sel = PAT_AMBER_ON;
        else if (cond.warn_run)
            pat_sel = PAT_AMBER_SLOW;
        else if (cond.main_good)
            pat_sel = PAT_GREEN_ON;
        else if (cond.ac_good && cond.standby_only)
            pat_sel = PAT_GREEN_SLOW;
        else
            pat_sel = PAT_DARK;
    end
endmodule

// File: rtl/led_phase_gen.sv
module led_phase_gen
    import led_status_pkg::*;
#(
    parameter int SLOW_HALF = 8,
    parameter int FAST_HALF = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  led_pat_e pat_sel,
    output led_pat_e pat_q,
    output logic     lit_q
);
    localparam int CW = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_HALF - 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    blink_rate_e   rate;

    always_comb begin
        rate = pat_rate(pat_q);
        lim  = (rate == RATE_FAST) ? FAST_LIM : SLOW_LIM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= PAT_DARK;
            cnt_q <= '0;
            lit_q <= 1'b1;
        end else if (pat_sel != pat_q) begin
            // New pattern: restart at the beginning of the lit half
            pat_q <= pat_sel;
            cnt_q <= '0;
            lit_q <= 1'b1;
        end else if (rate == RATE_SOLID) begin
            cnt_q <= '0;
            lit_q <= 1'b1;
        end else if (cnt_q == lim) begin
            cnt_q <= '0;
            lit_q <= ~lit_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/led_colour_map.sv
module led_colour_map
    import led_status_pkg::*;
(
    input  led_pat_e   pat_q,
    input  logic       lit_q,
    output led_drive_t drive
);
    always_comb begin
        drive = lit_q ? pat_colour(pat_q) : '0;
    end
endmodule

// File: rtl/status_led_ctrl.sv
module status_led_ctrl
    import led_status_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic ac_good,
    input  logic main_good,
    input  logic standby_only,
    input  logic warn_run,
    input  logic crit_stop,
    input  logic fw_update,
    output logic led_green,
    output logic led_amber
);
    localparam int SLOW_HALF = CLK_HZ / 2;
    localparam int FAST_HALF = CLK_HZ / 4;

    supply_cond_t cond;
    led_pat_e     pat_sel;
    led_pat_e     pat_q;
    logic         lit_q;
    led_drive_t   drive;

    always_comb begin
        cond.fw_update    = fw_update;
        cond.crit_stop    = crit_stop;
        cond.warn_run     = warn_run;
        cond.main_good    = main_good;
        cond.standby_only = standby_only;
        cond.ac_good      = ac_good;
    end

    led_prio_sel u_sel (
        .cond    (cond),
        .pat_sel (pat_sel)
    );

    led_phase_gen #(
        .SLOW_HALF (SLOW_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .pat_sel (pat_sel),
        .pat_q   (pat_q),
        .lit_q   (lit_q)
    );

    led_colour_map u_map (
        .pat_q (pat_q),
        .lit_q (lit_q),
        .drive (drive)
    );

    assign led_green = drive.green;
    assign led_amber = drive.amber;
endmodule

// File: rtl/status_led_chk.sv
module status_led_chk (
    input logic clk,
    input logic rst,
    input logic ac_good,
    input logic main_good,
    input logic standby_only,
    input logic warn_run,
    input logic crit_stop,
    input logic fw_update,
    input logic led_green,
    input logic led_amber
);
    // R9
    one_colour_chk: assert property (@(posedge clk) disable iff (rst)
        !(led_green && led_amber));

    // R6
    crit_amber_chk: assert property (@(posedge clk) disable iff (rst)
        (crit_stop && !fw_update) |=> (led_amber && !led_green));

    // R2
    main_green_chk: assert property (@(posedge clk) disable iff (rst)
        (main_good && !fw_update && !crit_stop && !warn_run) |=> (led_green && !led_amber));

    // R3
    dark_chk: assert property (@(posedge clk) disable iff (rst)
        (!fw_update && !crit_stop && !warn_run && !main_good && !(ac_good && standby_only))
        |=> (!led_green && !led_amber));

    // R5
    warn_no_green_chk: assert property (@(posedge clk) disable iff (rst)
        (warn_run && !crit_stop && !fw_update) |=> !led_green);

    // R10
    update_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (fw_update && !$past(fw_update)) |=> led_green);
endmodule

bind status_led_ctrl status_led_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ac_good      (ac_good),
    .main_good    (main_good),
    .standby_only (standby_only),
    .warn_run     (warn_run),
    .crit_stop    (crit_stop),
    .fw_update    (fw_update),
    .led_green    (led_green),
    .led_amber    (led_amber)
);

// File: tb/status_led_ctrl_tb_top.sv
module status_led_ctrl_tb_top;
    localparam int CLK_HZ = 16;
    localparam int SLOW   = CLK_HZ / 2;
    localparam int FAST   = CLK_HZ / 4;

    // kind codes for expected patterns
    localparam int K_DARK = 0, K_GON = 1, K_GSLOW = 2, K_ASLOW = 3, K_AON = 4, K_GFAST = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic ac_good, main_good, standby_only, warn_run, crit_stop, fw_update;
    logic led_green, led_amber;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    status_led_ctrl #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ac_good      (ac_good),
        .main_good    (main_good),
        .standby_only (standby_only),
        .warn_run     (warn_run),
        .crit_stop    (crit_stop),
        .fw_update    (fw_update),
        .led_green    (led_green),
        .led_amber    (led_amber)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: green/amber got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: flags = {fw, crit, warn, main, standby, ac}
    task automatic apply(input logic [5:0] flags, input int kind, input int n, input string tag);
        wait (exp_q.size() == 0);
        @(negedge clk);
        {fw_update, crit_stop, warn_run, main_good, standby_only, ac_good} = flags;
        for (int i = 0; i < n; i++) begin
            int half;
            logic on;
            logic [1:0] col;
            half = (kind == K_GFAST) ? FAST : SLOW;
            on = (kind == K_GSLOW || kind == K_ASLOW || kind == K_GFAST) ? (((i / half) % 2) == 0) : 1'b1;
            case (kind)
                K_GON, K_GSLOW, K_GFAST: col = 2'b10;
                K_AON, K_ASLOW:          col = 2'b01;
                default:                 col = 2'b00;
            endcase
            exp_q.push_back(on ? col : 2'b00);
            tag_q.push_back((i == 0) ? {tag, "/R11"} : tag);
        end
    endtask

    // Monitor: compares one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {led_green, led_amber}, e);
                // R9: never both colours
                check("R9", {1'b0, led_green && led_amber}, 2'b00);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {fw_update, crit_stop, warn_run, main_good, standby_only, ac_good} = '0;
        repeat (3) @(negedge clk);
        check("R1", {led_green, led_amber}, 2'b00);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", {led_green, led_amber}, 2'b00);

        apply(6'b000100, K_GON,   20, "R2");
        // standby without input power stays dark
        apply(6'b000010, K_DARK,  10, "R3");
        apply(6'b000011, K_GSLOW, 40, "R4");
        // main good outranks standby
        apply(6'b000111, K_GON,   10, "R8");
        apply(6'b001011, K_ASLOW, 40, "R5");
        // critical outranks warning and main good
        apply(6'b011111, K_AON,   20, "R6");
        // update mode outranks everything
        apply(6'b111111, K_GFAST, 24, "R7");
        // R10: leave a slow blink in its dark half, new pattern lit at once
        apply(6'b000011, K_GSLOW, 11, "R10");
        apply(6'b100000, K_GFAST, 16, "R10");
        apply(6'b000011, K_GSLOW, 12, "R10");
        apply(6'b001000, K_ASLOW, 20, "R10");
        apply(6'b000000, K_DARK,  10, "R3");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule